// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD for a larger timekeeping subsystem. A prescaler counts single-cycle enables from a 32.768 kHz source and makes one tick per second. Each tick moves the seconds counter forward, and carries ripple through minutes, hours, day of month, weekday, month and year in the same clock edge. A century flag flips each time the year wraps. Time is kept in 24-hour form only.

A host interface reaches the counters through a small register port. A write loads one register directly and restarts the sub-second prescaler. A read returns the chosen register through combinational logic. A stop input holds the prescaler at zero so that time does not move. A sticky voltage-low flag is set from an external detector input and is held until the host writes it back to 0.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count BCD 00..59 and hours count BCD 00..23. Each one wraps to 00 on the tick that follows its maximum and carries into the next field on that same edge.
- R2: Day of month counts BCD from 01 up to the month's length, then wraps to 01 and carries into the month. The length is 30 for months 04, 06, 09 and 11, and 31 for every other month except 02.
- R3: February has 29 days when the BCD year, read as a decimal number, is divisible by 4, and 28 days otherwise (for example 00, 12 and 24 are leap years; 10 and 23 are not).
- R4: The weekday is a 3-bit binary value. It moves forward by one on every day-of-month rollover and wraps from 6 to 0.
- R5: The month counts BCD 01..12 and wraps to 01 with a carry into the year. The year counts BCD 00..99.
- R6: Bit 7 of the month register is the century flag. It flips on the tick that takes the year from 99 to 00, and a host write to the month register loads it.
- R7: While stopIn is 1, the prescaler is held at 0 and time does not move. After stopIn returns to 0, a full PRESCALE enables are needed before the next tick.
- R8: A host write loads the addressed register and clears the prescaler. If the write falls in the same cycle as a tick, the write wins and that tick is dropped for every field.
- R9: Bit 7 of the seconds register is a voltage-low flag. Any cycle with lowVolt at 1 sets it. It then stays at 1 until a host write to the seconds register with bit 7 at 0.
- R10: The register map is: address 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year. Address 7 reads 0 and ignores writes. Bits that are not implemented read 0 and ignore writes: hours bits 7:6, day bits 7:6, weekday bits 7:3, month bits 6:5, minutes bit 7.
- R11: After reset the registers read: seconds 0x80 (voltage-low flag set), minutes 00, hours 00, day 01, weekday 0, month 0x01 (century 0), year 00.
- R12: One tick happens when the prescaler has seen PRESCALE enables since the last clear or the last tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One-cycle enable for each 32.768 kHz period |
| stopIn | input | 1 | Holds the prescaler cleared and freezes time |
| lowVolt | input | 1 | Voltage-low indication from the detector |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 3 | Host write register address |
| wrData | input | 8 | Host write data |
| rdAddr | input | 3 | Host read register address |
| rdData | output | 8 | Read data of the addressed register (combinational) |

## Verification
A host write and a prescaler tick can land on the same clock edge. The bench makes this happen by letting the prescaler reach its last count with oscEn held high, and then asserting a seconds write in that exact cycle. The check is that seconds reads back the written value, not the value plus one. After that, PRESCALE - 1 more enables must leave it unchanged, and the next enable must move it forward, which shows the prescaler was cleared. A second overlap is also covered: a single tick that carries through every field at once on year-end dates, where both century values are tried.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NumRegs = 7;

  // strobes passed from control to datapath
  typedef struct packed {
    logic               tick;
    logic [NumRegs-1:0] load;
  } calStrobe_t;

  // one BCD step for a two-digit value (caller handles wrap)
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return v + 8'h01;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       stopIn,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  output calStrobe_t strb
);
  localparam int CntW = $clog2(PRESCALE);
  localparam logic [CntW-1:0] CntMax = CntW'(PRESCALE - 1);

  logic [CntW-1:0]    preCnt;
  logic               tickW;
  logic [NumRegs-1:0] loadVec;

  // a write or stop clears the prescaler; a write suppresses the tick
  assign tickW = oscEn && (preCnt == CntMax) && !stopIn && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN)                 preCnt <= '0;
    else if (stopIn || wrEn)   preCnt <= '0;
    else if (oscEn)            preCnt <= (preCnt == CntMax) ? '0 : preCnt + 1'b1;
  end

  for (genvar i = 0; i < NumRegs; i++) begin : g_ld
    assign loadVec[i] = wrEn && (wrAddr == 3'(i));
  end

  assign strb = '{tick: tickW, load: loadVec};

  // R7: stop leaves the prescaler cleared
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopIn |=> (preCnt == '0));
  // R8: a host write restarts the prescaler
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (preCnt == '0));
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic       lowVolt,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  logic [6:0] sec, minute;
  logic [5:0] hour, day;
  logic [2:0] wday;
  logic [4:0] mon;
  logic [7:0] year;
  logic       vlFlag, cent;

  logic       secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;
  logic       cMin, cHour, cDay, cMon, cYear, cCent;
  logic       leapYr;
  logic [1:0] mod4;
  logic [5:0] dayMax;

  // decimal year mod 4: 10 = 2 (mod 4), so tens*2 + ones
  assign mod4   = {year[4], 1'b0} + year[1:0];
  assign leapYr = (mod4 == 2'd0);

  always_comb begin
    case (mon)
      5'h02:                      dayMax = leapYr ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dayMax = 6'h30;
      default:                    dayMax = 6'h31;
    endcase
  end

  assign secWrap  = (sec == 7'h59);
  assign minWrap  = (minute == 7'h59);
  assign hourWrap = (hour == 6'h23);
  assign dayWrap  = (day == dayMax);
  assign monWrap  = (mon == 5'h12);
  assign yearWrap = (year == 8'h99);

  assign cMin  = strb.tick & secWrap;
  assign cHour = cMin & minWrap;
  assign cDay  = cHour & hourWrap;
  assign cMon  = cDay & dayWrap;
  assign cYear = cMon & monWrap;
  assign cCent = cYear & yearWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec <= '0; minute <= '0; hour <= '0; day <= 6'h01;
      wday <= '0; mon <= 5'h01; year <= '0; cent <= 1'b0; vlFlag <= 1'b1;
    end else begin
      if (strb.load[0])      sec <= wrData[6:0];
      else if (strb.tick)    sec <= secWrap ? '0 : 7'(bcdInc({1'b0, sec}));

      if (strb.load[1])      minute <= wrData[6:0];
      else if (cMin)         minute <= minWrap ? '0 : 7'(bcdInc({1'b0, minute}));

      if (strb.load[2])      hour <= wrData[5:0];
      else if (cHour)        hour <= hourWrap ? '0 : 6'(bcdInc({2'b0, hour}));

      if (strb.load[3])      day <= wrData[5:0];
      else if (cDay)         day <= dayWrap ? 6'h01 : 6'(bcdInc({2'b0, day}));

      if (strb.load[4])      wday <= wrData[2:0];
      else if (cDay)         wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;

      if (strb.load[5])      mon <= wrData[4:0];
      else if (cMon)         mon <= monWrap ? 5'h01 : 5'(bcdInc({3'b0, mon}));

      if (strb.load[5])      cent <= wrData[7];
      else if (cCent)        cent <= ~cent;

      if (strb.load[6])      year <= wrData;
      else if (cYear)        year <= yearWrap ? '0 : bcdInc(year);

      if (lowVolt)           vlFlag <= 1'b1;
      else if (strb.load[0]) vlFlag <= wrData[7];
    end
  end

  always_comb begin
    case (rdAddr)
      3'd0:    rdData = {vlFlag, sec};
      3'd1:    rdData = {1'b0, minute};
      3'd2:    rdData = {2'b0, hour};
      3'd3:    rdData = {2'b0, day};
      3'd4:    rdData = {5'b0, wday};
      3'd5:    rdData = {cent, 2'b0, mon};
      3'd6:    rdData = year;
      default: rdData = 8'h00;
    endcase
  end

  // R1: seconds wrap to 00 after 59
  a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && secWrap) |=> (sec == 7'h00));
  // R4: weekday wraps 6 -> 0 on a day rollover
  a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cDay && wday == 3'd6 && !strb.load[4]) |=> (wday == 3'd0));
  // R5: year wraps 99 -> 00
  a_r5_year_wrap: assert property (@(posedge clk) disable iff (!rstN)
    cCent |=> (year == 8'h00));
  // R6: century flips on year rollover
  a_r6_century_flip: assert property (@(posedge clk) disable iff (!rstN)
    cCent |=> (cent != $past(cent)));
  // R9: voltage-low flag is sticky without a seconds write
  a_r9_vl_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (vlFlag && !strb.load[0]) |=> vlFlag);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       stopIn,
  input  logic       lowVolt,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  calStrobe_t strb;

  rtc_cal_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopIn(stopIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .lowVolt(lowVolt), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int ClkPeriod = 10;
  localparam int Pre = 4;
  localparam int NumVec = 17;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscEn = 1'b0, stopIn = 1'b0, lowVolt = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int         nChk = 0, nFail = 0;

  always #(ClkPeriod/2) clk = ~clk;

  rtc_calendar #(.PRESCALE(Pre)) dut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopIn(stopIn), .lowVolt(lowVolt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  // each entry: {start, expected} as {sec,min,hour,day,wday,month,year}
  localparam logic [111:0] Vecs [NumVec] = '{
    {56'h05_00_00_15_02_03_24, 56'h06_00_00_15_02_03_24},
    {56'h59_12_07_15_02_03_24, 56'h00_13_07_15_02_03_24},
    {56'h59_59_23_15_06_03_24, 56'h00_00_00_16_00_03_24},
    {56'h59_59_23_28_01_02_23, 56'h00_00_00_01_02_03_23},
    {56'h59_59_23_28_03_02_24, 56'h00_00_00_29_04_02_24},
    {56'h59_59_23_29_04_02_24, 56'h00_00_00_01_05_03_24},
    {56'h59_59_23_30_05_04_24, 56'h00_00_00_01_06_05_24},
    {56'h59_59_23_31_06_01_24, 56'h00_00_00_01_00_02_24},
    {56'h59_59_23_31_03_12_99, 56'h00_00_00_01_04_81_00},
    {56'h59_59_23_31_03_92_99, 56'h00_00_00_01_04_01_00},
    {56'h59_59_23_30_00_09_24, 56'h00_00_00_01_01_10_24},
    {56'h59_59_09_15_00_06_20, 56'h00_00_10_15_00_06_20},
    {56'h59_59_23_28_00_02_00, 56'h00_00_00_29_01_02_00},
    {56'h59_59_23_28_00_02_10, 56'h00_00_00_01_01_03_10},
    {56'h59_59_23_30_00_06_24, 56'h00_00_00_01_01_07_24},
    {56'h59_59_23_30_00_07_24, 56'h00_00_00_31_01_07_24},
    {56'h59_59_23_30_00_11_24, 56'h00_00_00_01_01_12_24}
  };

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 100000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic loadTime(input logic [55:0] t);
    for (int k = 0; k < 7; k++) regWrite(3'(k), t[55 - 8*k -: 8]);
  endtask

  task automatic readTime(output logic [55:0] t);
    logic [7:0] b;
    for (int k = 0; k < 7; k++) begin
      regRead(3'(k), b);
      t[55 - 8*k -: 8] = b;
    end
  endtask

  task automatic oneSecond();
    @(negedge clk); oscEn = 1'b1;
    repeat (Pre) @(negedge clk);
    oscEn = 1'b0;
  endtask

  initial begin
    logic [55:0] t;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset values
    readTime(t);
    chk("R11 reset state", 64'(t), 64'h80_00_00_01_00_01_00);
    regRead(3'd7, b);
    chk("R10 address 7 reads zero", 64'(b), 64'h0);

    // R1 R2 R3 R4 R5 R6 R12: one second from each start state
    for (int i = 0; i < NumVec; i++) begin
      loadTime(Vecs[i][111:56]);
      oneSecond();
      readTime(t);
      chk($sformatf("R1/R2/R3/R4/R5/R6/R12 vector %0d", i), 64'(t), 64'(Vecs[i][55:0]));
    end

    // R10: unimplemented bits read as zero
    regWrite(3'd1, 8'hFF); regRead(3'd1, b); chk("R10 minutes mask", 64'(b), 64'h7F);
    regWrite(3'd2, 8'hFF); regRead(3'd2, b); chk("R10 hours mask", 64'(b), 64'h3F);
    regWrite(3'd3, 8'hFF); regRead(3'd3, b); chk("R10 day mask", 64'(b), 64'h3F);
    regWrite(3'd4, 8'hFF); regRead(3'd4, b); chk("R10 weekday mask", 64'(b), 64'h07);
    regWrite(3'd5, 8'hFF); regRead(3'd5, b); chk("R10 month mask", 64'(b), 64'h9F);
    loadTime(56'h10_20_11_05_03_04_24);
    regWrite(3'd7, 8'hFF);
    regRead(3'd7, b); chk("R10 address 7 write ignored", 64'(b), 64'h0);
    readTime(t); chk("R10 address 7 leaves time", 64'(t), 64'h10_20_11_05_03_04_24);

    // R9: sticky voltage-low flag
    @(negedge clk); lowVolt = 1'b1;
    @(negedge clk); lowVolt = 1'b0;
    regRead(3'd0, b); chk("R9 flag set", 64'(b), 64'h90);
    repeat (3) @(negedge clk);
    regWrite(3'd1, 8'h21);
    regRead(3'd0, b); chk("R9 flag held", 64'(b), 64'h90);
    regWrite(3'd0, 8'h30);
    regRead(3'd0, b); chk("R9 flag cleared by write", 64'(b), 64'h30);

    // R8: write in the tick cycle wins and restarts the prescaler
    regWrite(3'd0, 8'h10);
    @(negedge clk); oscEn = 1'b1;
    repeat (Pre - 1) @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h20;
    @(negedge clk); wrEn = 1'b0;
    regRead(3'd0, b); chk("R8 write beats tick", 64'(b), 64'h20);
    regRead(3'd1, b); chk("R8 tick fully dropped", 64'(b), 64'h21);
    repeat (Pre - 1) @(negedge clk);
    regRead(3'd0, b); chk("R8 prescaler restarted", 64'(b), 64'h20);
    @(negedge clk);
    regRead(3'd0, b); chk("R8 R12 full second after write", 64'(b), 64'h21);
    oscEn = 1'b0;

    // R7: stop freezes time and clears the prescaler
    regWrite(3'd0, 8'h30);
    @(negedge clk); oscEn = 1'b1;
    repeat (2) @(negedge clk);
    stopIn = 1'b1;
    repeat (Pre + 1) @(negedge clk);
    regRead(3'd0, b); chk("R7 frozen while stopped", 64'(b), 64'h30);
    stopIn = 1'b0;
    repeat (Pre - 1) @(negedge clk);
    regRead(3'd0, b); chk("R7 prescaler cleared by stop", 64'(b), 64'h30);
    @(negedge clk);
    regRead(3'd0, b); chk("R7 resumes after stop", 64'(b), 64'h31);
    oscEn = 1'b0;

    finishRun();
  end
endmodule